// File: doc/BRIEF.md
# SDRAM Bank Read Command Sequencer

This block turns one read request into the timed command stream that a double-data-rate SDRAM needs to read from a single bank without automatic precharge. A request carries a bank, a row, a column and a flag. The flag selects whether the closing precharge targets every bank or only the addressed one. The block opens the row, reads the column, and closes the row. It inserts no-operation cycles wherever a minimum spacing has not yet been met.

The spacings are given in clock cycles. They cover row-to-column delay, minimum row-open time, precharge recovery and the minimum time between two row openings. A separate strobe marks every cycle that carries a real command. A data-window output is high during the clocks in which the memory returns the burst, counted from the read command and the configured CAS latency. The requester sees a valid/ready handshake. Ready stays low from the moment a request is taken until another row opening would be legal.

Top module: `sdram_rd_seq`

## Requirements
- R1: In the first cycle after reset the command pins show NOP (ras_n, cas_n, we_n = 1,1,1), cmd_stb is 0, sd_addr and sd_ba are 0, rd_window is 0 and req_ready is 1.
- R2: Commands are encoded as {ras_n,cas_n,we_n}: ACTIVE = 011, READ = 101, PRECHARGE = 010, NOP = 111. One request yields exactly ACTIVE, READ and PRECHARGE in that order, each for one cycle. cmd_stb is high only on those cycles. On every NOP cycle sd_addr and sd_ba are driven to 0.
- R3: READ appears exactly T_RCD cycles after ACTIVE.
- R4: During ACTIVE, sd_addr carries the requested row (zero-extended) and sd_ba carries the requested bank.
- R5: During READ, sd_addr bit 10 is 0, which disables auto precharge. Column bits below bit 10 sit at the same positions. Column bit k for k >= 10 sits at address bit k+1. sd_ba carries the requested bank.
- R6: During PRECHARGE, sd_addr bit 10 equals the all-banks flag of the request and every other address bit is 0. sd_ba carries the requested bank.
- R7: PRECHARGE appears exactly max(ACTIVE + T_RAS, READ + BURST_LEN/2) cycles into the sequence, never earlier.
- R8: rd_window is high for exactly BURST_LEN/2 consecutive cycles. The first of these is CAS_LAT cycles after READ.
- R9: req_ready falls in the ACTIVE cycle. It rises again exactly one cycle before max(PRECHARGE + T_RP, ACTIVE + T_RC). A request held pending gets its ACTIVE in exactly that cycle.
- R10: Bank, column and flag are captured at acceptance. Changing request inputs, or raising req_valid, while req_ready is low has no effect on the commands in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_bank | input | BANK_W | Bank to read |
| req_row | input | ROW_W | Row to open |
| req_col | input | COL_W | Starting column |
| req_all | input | 1 | Precharge all banks (1) or the addressed bank only (0) |
| sd_ras_n | output | 1 | Row strobe command pin |
| sd_cas_n | output | 1 | Column strobe command pin |
| sd_we_n | output | 1 | Write-enable command pin |
| cmd_stb | output | 1 | High on cycles that carry a non-NOP command |
| sd_addr | output | ADDR_W | Memory address pins |
| sd_ba | output | BANK_W | Memory bank pins |
| rd_window | output | 1 | High during the clocks of the returned burst |

## Verification
Two parameter sets are driven. In the first, the row-open minimum decides when the precharge happens and the row-cycle minimum decides the next activation. In the second, burst completion and precharge recovery decide these instead, so a wrong choice of the larger bound shows up on one set or the other. Column values with bit 10 set and clear, on an 11-bit and a 9-bit column, separate a correct skip of address bit 10 from a plain copy. Both flag values confirm the precharge encoding. Back-to-back requests with inputs changed mid-sequence show whether capture happens at acceptance and whether the pending request starts in the earliest legal cycle.

// File: rtl/rdseq_pkg.sv
package rdseq_pkg;

  // Command pin code {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_NOP = 3'b111,
    CMD_ACT = 3'b011,
    CMD_RD  = 3'b101,
    CMD_PRE = 3'b010
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_READ = 2'd2
  } seq_st_e;

endpackage

// File: rtl/rdseq_timer.sv
// Down-counter loaded when a command issues; zero means its spacing is met.
module rdseq_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/rdseq_colmap.sv
// Places column bits on the address pins, leaving the auto-precharge bit low.
module rdseq_colmap #(
  parameter int COL_W  = 11,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10
) (
  input  logic [COL_W-1:0]  col,
  output logic [ADDR_W-1:0] addr
);

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    if (i == AP_BIT) begin : g_ap
      assign addr[i] = 1'b0;
    end else if (i < AP_BIT) begin : g_lo
      if (i < COL_W) begin : g_c
        assign addr[i] = col[i];
      end else begin : g_z
        assign addr[i] = 1'b0;
      end
    end else begin : g_hi
      if (i - 1 < COL_W) begin : g_c
        assign addr[i] = col[i-1];
      end else begin : g_z
        assign addr[i] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/rdseq_rdwin.sv
// Delay line that turns a read issue into the returned-data window.
module rdseq_rdwin #(
  parameter int CAS_LAT = 2,
  parameter int BEATS   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic win
);

  localparam int PIPE = CAS_LAT + BEATS - 1;

  logic [PIPE-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_q <= '0;
      win    <= 1'b0;
    end else begin
      pipe_q[0] <= fire;
      for (int i = 1; i < PIPE; i++) begin
        pipe_q[i] <= pipe_q[i-1];
      end
      win <= |pipe_q[CAS_LAT-1 +: BEATS];
    end
  end

endmodule

// File: rtl/sdram_rd_seq.sv
module sdram_rd_seq
  import rdseq_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 11,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_RC      = 10,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_all,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              cmd_stb,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BANK_W-1:0] sd_ba,
  output logic              rd_window
);

  localparam int BEATS = BURST_LEN / 2;
  localparam int M1    = (T_RCD > T_RAS) ? T_RCD : T_RAS;
  localparam int M2    = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int M3    = (M1 > M2) ? M1 : M2;
  localparam int TMAX  = (M3 > BEATS) ? M3 : BEATS;
  localparam int CNT_W = $clog2(TMAX + 1);

  localparam int NT     = 5;
  localparam int TI_RCD = 0;
  localparam int TI_RAS = 1;
  localparam int TI_RC  = 2;
  localparam int TI_RP  = 3;
  localparam int TI_BST = 4;

  seq_st_e            st_q, st_d;
  sd_cmd_e            cmd_q;
  logic               stb_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [BANK_W-1:0]  ba_q;
  logic [BANK_W-1:0]  bank_q;
  logic [COL_W-1:0]   col_q;
  logic               all_q;

  logic               do_act, do_rd, do_pre;
  logic [NT-1:0]      t_load, t_zero;
  logic [CNT_W-1:0]   t_val [NT];
  logic [ADDR_W-1:0]  col_addr, pre_addr;

  // Spacing timers
  assign t_load[TI_RCD] = do_act;
  assign t_load[TI_RAS] = do_act;
  assign t_load[TI_RC]  = do_act;
  assign t_load[TI_RP]  = do_pre;
  assign t_load[TI_BST] = do_rd;

  assign t_val[TI_RCD] = CNT_W'(T_RCD - 1);
  assign t_val[TI_RAS] = CNT_W'(T_RAS - 1);
  assign t_val[TI_RC]  = CNT_W'(T_RC - 1);
  assign t_val[TI_RP]  = CNT_W'(T_RP - 1);
  assign t_val[TI_BST] = CNT_W'(BEATS - 1);

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    rdseq_timer #(.W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load[g]),
      .load_val (t_val[g]),
      .zero     (t_zero[g])
    );
  end

  // Issue decisions
  assign req_ready = (st_q == ST_IDLE) && t_zero[TI_RP] && t_zero[TI_RC];
  assign do_act    = req_valid && req_ready;
  assign do_rd     = (st_q == ST_OPEN) && t_zero[TI_RCD];
  assign do_pre    = (st_q == ST_READ) && t_zero[TI_BST] && t_zero[TI_RAS];

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (do_act) st_d = ST_OPEN;
      ST_OPEN: if (do_rd)  st_d = ST_READ;
      ST_READ: if (do_pre) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // Address formatting
  rdseq_colmap #(
    .COL_W  (COL_W),
    .ADDR_W (ADDR_W),
    .AP_BIT (AP_BIT)
  ) u_colmap (
    .col  (col_q),
    .addr (col_addr)
  );

  always_comb begin
    pre_addr         = '0;
    pre_addr[AP_BIT] = all_q;
  end

  // Registered pin drive
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cmd_q  <= CMD_NOP;
      stb_q  <= 1'b0;
      addr_q <= '0;
      ba_q   <= '0;
      bank_q <= '0;
      col_q  <= '0;
      all_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (do_act) begin
        bank_q <= req_bank;
        col_q  <= req_col;
        all_q  <= req_all;
      end
      stb_q <= do_act || do_rd || do_pre;
      if (do_act) begin
        cmd_q  <= CMD_ACT;
        addr_q <= ADDR_W'(req_row);
        ba_q   <= req_bank;
      end else if (do_rd) begin
        cmd_q  <= CMD_RD;
        addr_q <= col_addr;
        ba_q   <= bank_q;
      end else if (do_pre) begin
        cmd_q  <= CMD_PRE;
        addr_q <= pre_addr;
        ba_q   <= bank_q;
      end else begin
        cmd_q  <= CMD_NOP;
        addr_q <= '0;
        ba_q   <= '0;
      end
    end
  end

  assign sd_ras_n = cmd_q[2];
  assign sd_cas_n = cmd_q[1];
  assign sd_we_n  = cmd_q[0];
  assign cmd_stb  = stb_q;
  assign sd_addr  = addr_q;
  assign sd_ba    = ba_q;

  // Returned-data window
  rdseq_rdwin #(
    .CAS_LAT (CAS_LAT),
    .BEATS   (BEATS)
  ) u_rdwin (
    .clk  (clk),
    .rst  (rst),
    .fire (do_rd),
    .win  (rd_window)
  );

endmodule

// File: rtl/rdseq_chk.sv
module rdseq_chk
  import rdseq_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_RC      = 10,
  parameter int CAS_LAT   = 2,
  parameter int BURST_LEN = 4
) (
  input logic clk,
  input logic rst,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic cmd_stb,
  input logic ap_bit,
  input logic rd_window,
  input logic req_ready
);

  localparam int BEATS = BURST_LEN / 2;

  logic [2:0]  cmd;
  logic        is_act, is_rd, is_pre;
  logic [31:0] since_act, since_rd, since_pre;

  assign cmd    = {ras_n, cas_n, we_n};
  assign is_act = (cmd == CMD_ACT);
  assign is_rd  = (cmd == CMD_RD);
  assign is_pre = (cmd == CMD_PRE);

  // Cycles since the last command of each kind, saturating; all-ones = never
  always_ff @(posedge clk) begin
    if (rst) begin
      since_act <= '1;
      since_rd  <= '1;
      since_pre <= '1;
    end else begin
      since_act <= is_act ? 32'd1 : ((since_act != '1) ? since_act + 1 : since_act);
      since_rd  <= is_rd  ? 32'd1 : ((since_rd  != '1) ? since_rd  + 1 : since_rd);
      since_pre <= is_pre ? 32'd1 : ((since_pre != '1) ? since_pre + 1 : since_pre);
    end
  end

  a_r2_stb_marks_cmd: assert property (@(posedge clk) disable iff (rst)
    cmd_stb == (cmd != CMD_NOP));

  a_r3_read_spacing: assert property (@(posedge clk) disable iff (rst)
    is_rd |-> since_act == 32'(T_RCD));

  a_r5_read_no_autopre: assert property (@(posedge clk) disable iff (rst)
    is_rd |-> !ap_bit);

  a_r7_pre_after_ras: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> since_act >= 32'(T_RAS));

  a_r7_pre_after_burst: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> since_rd >= 32'(BEATS));

  a_r8_window_place: assert property (@(posedge clk) disable iff (rst)
    rd_window |-> (since_rd >= 32'(CAS_LAT)) && (since_rd < 32'(CAS_LAT + BEATS)));

  a_r9_act_spacing: assert property (@(posedge clk) disable iff (rst)
    is_act |-> (since_act >= 32'(T_RC)) && (since_pre >= 32'(T_RP)));

  a_r9_ready_rc_low: assert property (@(posedge clk) disable iff (rst)
    (since_act < 32'(T_RC - 1)) |-> !req_ready);

  a_r9_ready_rp_low: assert property (@(posedge clk) disable iff (rst)
    (since_pre < 32'(T_RP - 1)) |-> !req_ready);

endmodule

bind sdram_rd_seq rdseq_chk #(
  .T_RCD     (T_RCD),
  .T_RAS     (T_RAS),
  .T_RP      (T_RP),
  .T_RC      (T_RC),
  .CAS_LAT   (CAS_LAT),
  .BURST_LEN (BURST_LEN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ras_n     (sd_ras_n),
  .cas_n     (sd_cas_n),
  .we_n      (sd_we_n),
  .cmd_stb   (cmd_stb),
  .ap_bit    (sd_addr[AP_BIT]),
  .rd_window (rd_window),
  .req_ready (req_ready)
);

// File: tb/sim_sdram_rd_seq.sv
`timescale 1ns/1ps

// Port observer: records the cycle and pins of each command seen
module sim_rdseq_mon (
  input  logic        clk,
  input  logic        rst,
  input  int          cyc,
  input  logic        ras_n,
  input  logic        cas_n,
  input  logic        we_n,
  input  logic        stb,
  input  logic [12:0] addr,
  input  logic [1:0]  ba,
  input  logic        win,
  input  logic        rdy,
  output int          act_cyc,
  output int          rd_cyc,
  output int          pre_cyc,
  output logic [12:0] act_addr,
  output logic [12:0] rd_addr,
  output logic [12:0] pre_addr,
  output logic [1:0]  act_ba,
  output logic [1:0]  rd_ba,
  output logic [1:0]  pre_ba,
  output int          win_start,
  output int          win_len,
  output int          rdy_cyc,
  output int          bad
);
  logic win_prev, rdy_prev;
  always @(negedge clk) begin
    if (rst) begin
      act_cyc = -1; rd_cyc = -1; pre_cyc = -1; win_start = -1; win_len = 0;
      rdy_cyc = -1; bad = 0; win_prev = 1'b0; rdy_prev = 1'b0;
      act_addr = '0; rd_addr = '0; pre_addr = '0; act_ba = '0; rd_ba = '0; pre_ba = '0;
    end else begin
      if (stb != ({ras_n, cas_n, we_n} != 3'b111)) bad++;
      if (stb) begin
        case ({ras_n, cas_n, we_n})
          3'b011:  begin act_cyc = cyc; act_addr = addr; act_ba = ba; end
          3'b101:  begin rd_cyc = cyc; rd_addr = addr; rd_ba = ba; end
          3'b010:  begin pre_cyc = cyc; pre_addr = addr; pre_ba = ba; end
          default: bad++;
        endcase
      end else if (addr != '0 || ba != '0) begin
        bad++;
      end
      if (win) begin
        if (!win_prev) begin win_start = cyc; win_len = 0; end
        win_len++;
      end
      win_prev = win;
      if (rdy && !rdy_prev) rdy_cyc = cyc;
      rdy_prev = rdy;
    end
  end
endmodule

module sim_sdram_rd_seq;

  // Per-instance timing: [0] row-open and row-cycle bound; [1] burst and recovery bound
  int p_rcd [2] = '{3, 3};
  int p_ras [2] = '{6, 3};
  int p_rp  [2] = '{3, 3};
  int p_rc  [2] = '{10, 6};
  int p_cl  [2] = '{2, 3};
  int p_bl  [2] = '{4, 4};
  int p_colw[2] = '{11, 9};

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;

  logic        v    [2];
  logic [1:0]  bk   [2];
  logic [12:0] rw   [2];
  logic [10:0] cl   [2];
  logic        al_i [2];
  logic        rdy_o[2];
  logic        ras_o[2], cas_o[2], we_o[2], stb_o[2], win_o[2];
  logic [12:0] addr_o[2];
  logic [1:0]  ba_o [2];

  int          act_c[2], rd_c[2], pre_c[2], ws[2], wl[2], rdy_c[2], bad_c[2];
  logic [12:0] aa[2], ra[2], pa[2];
  logic [1:0]  ab[2], rb[2], pb[2];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_rd_seq u0 (
    .clk(clk), .rst(rst), .req_valid(v[0]), .req_ready(rdy_o[0]),
    .req_bank(bk[0]), .req_row(rw[0]), .req_col(cl[0]), .req_all(al_i[0]),
    .sd_ras_n(ras_o[0]), .sd_cas_n(cas_o[0]), .sd_we_n(we_o[0]), .cmd_stb(stb_o[0]),
    .sd_addr(addr_o[0]), .sd_ba(ba_o[0]), .rd_window(win_o[0])
  );

  sdram_rd_seq #(
    .COL_W(9), .T_RCD(3), .T_RAS(3), .T_RP(3), .T_RC(6), .CAS_LAT(3), .BURST_LEN(4)
  ) u1 (
    .clk(clk), .rst(rst), .req_valid(v[1]), .req_ready(rdy_o[1]),
    .req_bank(bk[1]), .req_row(rw[1]), .req_col(cl[1][8:0]), .req_all(al_i[1]),
    .sd_ras_n(ras_o[1]), .sd_cas_n(cas_o[1]), .sd_we_n(we_o[1]), .cmd_stb(stb_o[1]),
    .sd_addr(addr_o[1]), .sd_ba(ba_o[1]), .rd_window(win_o[1])
  );

  for (genvar k = 0; k < 2; k++) begin : g_mon
    sim_rdseq_mon m (
      .clk(clk), .rst(rst), .cyc(cyc), .ras_n(ras_o[k]), .cas_n(cas_o[k]), .we_n(we_o[k]),
      .stb(stb_o[k]), .addr(addr_o[k]), .ba(ba_o[k]), .win(win_o[k]), .rdy(rdy_o[k]),
      .act_cyc(act_c[k]), .rd_cyc(rd_c[k]), .pre_cyc(pre_c[k]),
      .act_addr(aa[k]), .rd_addr(ra[k]), .pre_addr(pa[k]),
      .act_ba(ab[k]), .rd_ba(rb[k]), .pre_ba(pb[k]),
      .win_start(ws[k]), .win_len(wl[k]), .rdy_cyc(rdy_c[k]), .bad(bad_c[k])
    );
  end

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R5 column placement: bits below 10 in place, bit 10 low, higher bits shifted up one
  function automatic logic [12:0] map_col(input logic [10:0] c, input int colw);
    logic [12:0] m = '0;
    for (int i = 0; i < 13; i++) begin
      if (i < 10)       m[i] = (i < colw) ? c[i] : 1'b0;
      else if (i == 10) m[i] = 1'b0;
      else              m[i] = (i - 1 < colw) ? c[i-1] : 1'b0;
    end
    return m;
  endfunction

  task automatic ck(input string rq, input string what, input longint actv, input longint expv);
    n_cmp++;
    if (actv != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, actv, expv);
    end
  endtask

  task automatic send(input int s, input logic [1:0] b, input logic [12:0] r,
                      input logic [10:0] c, input logic a, output int acc);
    @(negedge clk);
    v[s] = 1'b1; bk[s] = b; rw[s] = r; cl[s] = c; al_i[s] = a;
    while (!rdy_o[s]) @(negedge clk);
    acc = cyc + 1;
    @(negedge clk);
    // R10: scramble the inputs once the request has been taken
    v[s] = 1'b0; bk[s] = ~b; rw[s] = ~r; cl[s] = ~c; al_i[s] = ~a;
  endtask

  task automatic t_reset();
    #1;
    for (int s = 0; s < 2; s++) begin
      ck("R1", "cmd pins", {ras_o[s], cas_o[s], we_o[s]}, 3'b111);
      ck("R1", "cmd_stb", stb_o[s], 0);
      ck("R1", "addr/ba", {addr_o[s], ba_o[s]}, 0);
      ck("R1", "rd_window", win_o[s], 0);
      ck("R1", "req_ready", rdy_o[s], 1);
    end
  endtask

  task automatic t_single(input int s, input logic [1:0] b, input logic [12:0] r,
                          input logic [10:0] c, input logic a);
    int acc, rd_e, pre_e, nxt_e;
    send(s, b, r, c, a, acc);
    repeat (16) @(negedge clk);
    #1;
    rd_e  = acc + p_rcd[s];
    pre_e = imax(acc + p_ras[s], rd_e + p_bl[s] / 2);
    nxt_e = imax(pre_e + p_rp[s], acc + p_rc[s]);
    ck("R2", "ACTIVE cycle", act_c[s], acc);
    ck("R3", "READ cycle", rd_c[s], rd_e);
    ck("R4", "ACTIVE addr", aa[s], r);
    ck("R4", "ACTIVE bank", ab[s], b);
    ck("R5", "READ addr", ra[s], map_col(c, p_colw[s]));
    ck("R5", "READ bit10", ra[s][10], 0);
    ck("R5", "READ bank", rb[s], b);
    ck("R6", "PRE addr", pa[s], {2'b00, a, 10'd0});
    ck("R6", "PRE bank", pb[s], b);
    ck("R7", "PRE cycle", pre_c[s], pre_e);
    ck("R8", "window start", ws[s], rd_e + p_cl[s]);
    ck("R8", "window length", wl[s], p_bl[s] / 2);
    ck("R9", "ready rise", rdy_c[s], nxt_e - 1);
    ck("R2", "encoding errors", bad_c[s], 0);
  endtask

  task automatic t_b2b(input int s);
    int acc, pre_e, nxt_e;
    logic [1:0]  b1 = 2'd2, b2 = 2'd1;
    logic [12:0] r1 = 13'h0A5A, r2 = 13'h1234;
    logic [10:0] c1 = 11'h2C3, c2 = 11'h4F0;
    send(s, b1, r1, c1, 1'b0, acc);
    // R10: second request raised and held while ready is low
    @(negedge clk);
    v[s] = 1'b1; bk[s] = b2; rw[s] = r2; cl[s] = c2; al_i[s] = 1'b1;
    pre_e = imax(acc + p_ras[s], acc + p_rcd[s] + p_bl[s] / 2);
    nxt_e = imax(pre_e + p_rp[s], acc + p_rc[s]);
    while (cyc < pre_e + 1) @(negedge clk);
    #1;
    ck("R10", "first READ addr", ra[s], map_col(c1, p_colw[s]));
    ck("R10", "first PRE addr", pa[s], 0);
    ck("R10", "first PRE bank", pb[s], b1);
    ck("R10", "first ACTIVE addr", aa[s], r1);
    while (cyc < nxt_e + 1) @(negedge clk);
    #1;
    ck("R9", "pending ACTIVE cycle", act_c[s], nxt_e);
    ck("R10", "second ACTIVE addr", aa[s], r2);
    ck("R10", "second ACTIVE bank", ab[s], b2);
    v[s] = 1'b0;
    repeat (16) @(negedge clk);
    #1;
    ck("R5", "second READ addr", ra[s], map_col(c2, p_colw[s]));
    ck("R6", "second PRE addr", pa[s], {2'b00, 1'b1, 10'd0});
    ck("R2", "encoding errors", bad_c[s], 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog R9 actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      v[s] = 1'b0; bk[s] = '0; rw[s] = '0; cl[s] = '0; al_i[s] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_single(0, 2'd1, 13'h1ABC, 11'h5A5, 1'b0);
    t_single(0, 2'd3, 13'h0F0F, 11'h3FF, 1'b1);
    t_b2b(0);
    t_single(1, 2'd2, 13'h1555, 11'h0AA, 1'b1);
    t_single(1, 2'd0, 13'h0001, 11'h1FF, 1'b0);
    t_b2b(1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule